// File: doc/BRIEF.md
# Pointer-Indexed FIFO Host Register Interface

This block is the host-side register front end of a bidirectional byte FIFO device. The host reaches it through an eight-byte I/O window. Offset 0 is a byte data port to the two FIFOs. Offset 7 is a write-only board reset. Offset 2 carries most of the control. A read at offset 2 returns a status byte. A write at offset 2 loads an index pointer. Once the pointer holds a valid index, the next single read or write at offset 2 reaches one of six internal registers: command, interrupt enable mask, byte-detect value, outbound mailbox, threshold value or inbound mailbox. After that one access, offset 2 goes back to its status and pointer role.

The FIFO memories and the board-side processor are outside the block. The FIFOs appear as level flag inputs and one-cycle data strobes. The data port has no back-pressure: the host must check the full and empty status bits before it transfers data, and every strobe is taken as issued. The board side has three pulses:
- one consumes the outbound mailbox;
- one loads the inbound mailbox;
- one enables host interrupts.

A level interrupt goes to the host whenever an enabled status condition is present. The board side must enable interrupts first.

Top module: `fifo_host_regif`

## Requirements
- R1: Offset 0 decoding. A write at offset 0 drives `ob_push` high for that cycle with `ob_pdata` equal to the written byte. A read at offset 0 drives `ib_pop` high and returns `ib_fdata`.
- R1 (continued): Other offsets. A read of offset 7 changes no state. Offsets 1, 3, 4, 5 and 6 read as 0x00, and writes to them change nothing.
- R2: Pointer loading. When no index is pending, a write at offset 2 loads the pointer. The values select as follows: 1 command, 2 interrupt mask, 3 byte-detect, 4 outbound mailbox, 5 threshold, 6 inbound mailbox. The value 0, and every value from 7 upward, leaves no selection, so the next read at offset 2 returns status.
- R3: One-shot index. A pending index is consumed by exactly the next read or write at offset 2, and that access goes to the selected register. Accesses at other offsets leave the pending index in place.
- R4: Status byte layout. Bit 7 is the reset flag, bit 6 outbound full, bit 5 inbound empty, bit 4 outbound almost full, bit 3 inbound almost empty, bit 2 inbound mailbox full, bit 1 byte detected and bit 0 parity/framing. Bits 6..0 follow their conditions as levels. While the command register is in shifted mode, the status read returns `peer_stat` in place of the local byte.
- R5: Reset flag. The reset flag (bit 7) is set by `rst_n`, by a clear command and by a board reset. Any status read clears it. The mask cannot block it.
- R6: Host interrupt. Mask bits 6..0 line up with status bits 6..0, and a 1 enables that bit. `host_irq` is high when global enable is on and either an enabled local status bit is set or the reset flag is set.
- R7: Global enable. Global interrupt enable is off after `rst_n` and after a board reset. A `bd_irq_en` pulse turns it on.
- R8: Command register. Writing 0x80 pulses `fifo_clr` for one cycle, sets the reset flag and empties both mailboxes. Writing 0x40 selects shifted status and writing 0x00 restores local status. Other values are ignored. A read of the command register returns 0x40 when shifted and 0x00 otherwise.
- R9: Outbound mailbox, host side. A host write to the outbound mailbox stores the byte and raises `ob_mbox_full`.
- R9 (continued): Outbound mailbox, board side. A `bd_ob_take` pulse clears both the byte and the flag, so a readback of 0x00 means the board has consumed it. A host write in the same cycle as `bd_ob_take` wins.
- R10: Inbound mailbox. A `bd_ib_put` pulse stores `bd_ib_data` and sets status bit 2. A host read of the inbound mailbox clears bit 2. Host writes to it are ignored.
- R11: Board reset. Any write at offset 7 returns every register to its reset value, clears a pending index, and pulses `board_rst` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Byte offset in the window |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| ob_push | output | 1 | Outbound FIFO push strobe |
| ob_pdata | output | 8 | Outbound FIFO push data |
| ib_pop | output | 1 | Inbound FIFO pop strobe |
| ib_fdata | input | 8 | Inbound FIFO head byte |
| ob_full_in | input | 1 | Outbound FIFO full level |
| ib_empty_in | input | 1 | Inbound FIFO empty level |
| ob_afull_in | input | 1 | Outbound almost-full level |
| ib_aempty_in | input | 1 | Inbound almost-empty level |
| bdet_hit_in | input | 1 | Byte-detect match level |
| perr_in | input | 1 | Parity/framing condition level |
| peer_stat | input | 8 | Other port's status byte |
| bd_ob_take | input | 1 | Board consumed outbound mailbox |
| bd_ib_put | input | 1 | Board writes inbound mailbox |
| bd_ib_data | input | 8 | Inbound mailbox data from board |
| bd_irq_en | input | 1 | Board enables host interrupts |
| ob_mbox_data | output | 8 | Outbound mailbox contents |
| ob_mbox_full | output | 1 | Outbound mailbox holds unread data |
| bdet_val | output | 8 | Byte-detect register |
| thr_val | output | 8 | Threshold register |
| fifo_clr | output | 1 | One-cycle FIFO clear pulse |
| board_rst | output | 1 | One-cycle board reset pulse |
| host_irq | output | 1 | Level interrupt to host |

## Verification
The hardest state to reach is a pending index that must survive unrelated traffic. The pointer is loaded, then accesses at other offsets and a read of offset 7 arrive before the consuming access at offset 2. The stimulus places those accesses between pointer load and use, and checks that the selected register, not status, answers.

The interrupt's unmaskable reset flag also needs a planned sequence. The mask is first cleared to zero and global enable turned on. Only then is the clear command issued, so any interrupt that appears can come from the reset flag alone.

// File: rtl/fhr_pkg.sv
package fhr_pkg;
  localparam int unsigned BW = 8;
  localparam int unsigned AW = 3;
  localparam int unsigned SW = 3;
  localparam int unsigned NSEL = 6;

  typedef logic [BW-1:0] byte_t;

  typedef enum logic [SW-1:0] {
    SEL_NONE = 3'd0,
    SEL_CMD  = 3'd1,
    SEL_MASK = 3'd2,
    SEL_BDET = 3'd3,
    SEL_OMB  = 3'd4,
    SEL_THR  = 3'd5,
    SEL_IMB  = 3'd6
  } sel_e;

  localparam logic [AW-1:0] OFS_DATA = 3'd0;
  localparam logic [AW-1:0] OFS_CTL  = 3'd2;
  localparam logic [AW-1:0] OFS_RST  = 3'd7;

  localparam byte_t CMD_CLR     = 8'h80;
  localparam byte_t CMD_SHIFT   = 8'h40;
  localparam byte_t CMD_UNSHIFT = 8'h00;

  function automatic sel_e decode_sel(byte_t v);
    if (v >= byte_t'(1) && v <= byte_t'(NSEL)) return sel_e'(v[SW-1:0]);
    return SEL_NONE;
  endfunction
endpackage

// File: rtl/fhr_ptr_ctl.sv
module fhr_ptr_ctl
  import fhr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  srst,
  input  logic  acc_rd,
  input  logic  acc_wr,
  input  byte_t wdata,
  output sel_e  sel
);
  sel_e sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SEL_NONE;
    end else if (srst) begin
      sel_q <= SEL_NONE;
    end else if (acc_rd || acc_wr) begin
      if (sel_q != SEL_NONE) sel_q <= SEL_NONE;
      else if (acc_wr)       sel_q <= decode_sel(wdata);
    end
  end

  assign sel = sel_q;

  AST_PTR_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_rd || acc_wr) && sel_q != SEL_NONE) |=> (sel_q == SEL_NONE)); // R3
  AST_PTR_BADVAL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && sel_q == SEL_NONE && (wdata == '0 || wdata > byte_t'(NSEL))) |=> (sel_q == SEL_NONE)); // R2
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_rd && !acc_wr && !srst) |=> $stable(sel_q)); // R3
endmodule

// File: rtl/fhr_mbox.sv
module fhr_mbox
  import fhr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  srst,
  input  logic  clr,
  input  logic  h_ob_wr,
  input  byte_t h_ob_wdata,
  input  logic  bd_ob_take,
  input  logic  h_ib_rd,
  input  logic  bd_ib_put,
  input  byte_t bd_ib_data,
  output byte_t ob_data,
  output logic  ob_full,
  output byte_t ib_data,
  output logic  ib_full
);
  byte_t ob_q, ib_q;
  logic  obf_q, ibf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ob_q  <= '0;
      obf_q <= 1'b0;
    end else if (srst || clr) begin
      ob_q  <= '0;
      obf_q <= 1'b0;
    end else if (h_ob_wr) begin
      ob_q  <= h_ob_wdata;
      obf_q <= 1'b1;
    end else if (bd_ob_take) begin
      ob_q  <= '0;
      obf_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ib_q  <= '0;
      ibf_q <= 1'b0;
    end else if (srst || clr) begin
      ib_q  <= '0;
      ibf_q <= 1'b0;
    end else if (bd_ib_put) begin
      ib_q  <= bd_ib_data;
      ibf_q <= 1'b1;
    end else if (h_ib_rd) begin
      ibf_q <= 1'b0;
    end
  end

  assign ob_data = ob_q;
  assign ob_full = obf_q;
  assign ib_data = ib_q;
  assign ib_full = ibf_q;

  AST_OBMB_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (bd_ob_take && !h_ob_wr) |=> (ob_q == '0 && !obf_q)); // R9
  AST_OBMB_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (h_ob_wr && !srst && !clr) |=> obf_q); // R9
  AST_IBMB_PUT: assert property (@(posedge clk) disable iff (!rst_n)
    (bd_ib_put && !srst && !clr) |=> ibf_q); // R10
  AST_IBMB_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (h_ib_rd && !bd_ib_put) |=> !ibf_q); // R10
endmodule

// File: rtl/fhr_status.sv
module fhr_status
  import fhr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic          set_flag,
  input  logic          stat_rd,
  input  logic [BW-2:0] cond,
  input  byte_t         peer_stat,
  input  logic          shift,
  input  logic [BW-2:0] mask,
  input  logic          irq_en_set,
  output byte_t         stat_byte,
  output logic          host_irq
);
  logic rflag_q;
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rflag_q <= 1'b1;
      en_q    <= 1'b0;
    end else if (srst) begin
      rflag_q <= 1'b1;
      en_q    <= 1'b0;
    end else begin
      if (set_flag)     rflag_q <= 1'b1;
      else if (stat_rd) rflag_q <= 1'b0;
      if (irq_en_set)   en_q    <= 1'b1;
    end
  end

  assign stat_byte = shift ? peer_stat : {rflag_q, cond};
  assign host_irq  = en_q && (rflag_q || ((cond & mask) != '0));

  AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !set_flag && !srst) |=> !rflag_q); // R5
  AST_FLAG_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (rflag_q && en_q) |-> host_irq); // R5
  AST_SRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> !host_irq); // R7
  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !srst) |=> en_q); // R7
endmodule

// File: rtl/fifo_host_regif.sv
module fifo_host_regif
  import fhr_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   bus_addr,
  input  logic         bus_rd,
  input  logic         bus_wr,
  input  logic [7:0]   bus_wdata,
  output logic [7:0]   bus_rdata,
  output logic         ob_push,
  output logic [7:0]   ob_pdata,
  output logic         ib_pop,
  input  logic [7:0]   ib_fdata,
  input  logic         ob_full_in,
  input  logic         ib_empty_in,
  input  logic         ob_afull_in,
  input  logic         ib_aempty_in,
  input  logic         bdet_hit_in,
  input  logic         perr_in,
  input  logic [7:0]   peer_stat,
  input  logic         bd_ob_take,
  input  logic         bd_ib_put,
  input  logic [7:0]   bd_ib_data,
  input  logic         bd_irq_en,
  output logic [7:0]   ob_mbox_data,
  output logic         ob_mbox_full,
  output logic [7:0]   bdet_val,
  output logic [7:0]   thr_val,
  output logic         fifo_clr,
  output logic         board_rst,
  output logic         host_irq
);
  logic rd, wr, acc_rd, acc_wr, srst;
  logic sel_wr, sel_rd, stat_rd, cmd_clr;
  sel_e sel;
  byte_t mask_q, bdet_q, thr_q, stat_byte, ob_data, ib_data;
  logic shift_q, ob_full, ib_full, clr_q, brst_q;
  logic [BW-2:0] cond;

  assign rd      = bus_rd && !bus_wr;
  assign wr      = bus_wr;
  assign acc_rd  = rd && bus_addr == OFS_CTL;
  assign acc_wr  = wr && bus_addr == OFS_CTL;
  assign srst    = wr && bus_addr == OFS_RST;
  assign sel_wr  = acc_wr && sel != SEL_NONE;
  assign sel_rd  = acc_rd && sel != SEL_NONE;
  assign stat_rd = acc_rd && sel == SEL_NONE;
  assign cmd_clr = sel_wr && sel == SEL_CMD && bus_wdata == CMD_CLR;

  assign ob_push  = wr && bus_addr == OFS_DATA;
  assign ob_pdata = bus_wdata;
  assign ib_pop   = rd && bus_addr == OFS_DATA;

  fhr_ptr_ctl u_ptr (
    .clk(clk), .rst_n(rst_n), .srst(srst),
    .acc_rd(acc_rd), .acc_wr(acc_wr), .wdata(bus_wdata), .sel(sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      bdet_q  <= '0;
      thr_q   <= '0;
      shift_q <= 1'b0;
    end else if (srst) begin
      mask_q  <= '0;
      bdet_q  <= '0;
      thr_q   <= '0;
      shift_q <= 1'b0;
    end else if (sel_wr) begin
      unique case (sel)
        SEL_MASK: mask_q <= bus_wdata;
        SEL_BDET: bdet_q <= bus_wdata;
        SEL_THR:  thr_q  <= bus_wdata;
        SEL_CMD: begin
          if (bus_wdata == CMD_SHIFT)        shift_q <= 1'b1;
          else if (bus_wdata == CMD_UNSHIFT) shift_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q  <= 1'b0;
      brst_q <= 1'b0;
    end else begin
      clr_q  <= cmd_clr;
      brst_q <= srst;
    end
  end

  fhr_mbox u_mbox (
    .clk(clk), .rst_n(rst_n), .srst(srst), .clr(cmd_clr),
    .h_ob_wr(sel_wr && sel == SEL_OMB), .h_ob_wdata(bus_wdata),
    .bd_ob_take(bd_ob_take),
    .h_ib_rd(sel_rd && sel == SEL_IMB),
    .bd_ib_put(bd_ib_put), .bd_ib_data(bd_ib_data),
    .ob_data(ob_data), .ob_full(ob_full), .ib_data(ib_data), .ib_full(ib_full)
  );

  assign cond = {ob_full_in, ib_empty_in, ob_afull_in, ib_aempty_in, ib_full, bdet_hit_in, perr_in};

  fhr_status u_stat (
    .clk(clk), .rst_n(rst_n), .srst(srst), .set_flag(cmd_clr), .stat_rd(stat_rd),
    .cond(cond), .peer_stat(peer_stat), .shift(shift_q), .mask(mask_q[BW-2:0]),
    .irq_en_set(bd_irq_en), .stat_byte(stat_byte), .host_irq(host_irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (bus_addr == OFS_DATA) begin
        bus_rdata = ib_fdata;
      end else if (bus_addr == OFS_CTL) begin
        if (sel == SEL_NONE) bus_rdata = stat_byte;
        else begin
          unique case (sel)
            SEL_CMD:  bus_rdata = shift_q ? CMD_SHIFT : CMD_UNSHIFT;
            SEL_MASK: bus_rdata = mask_q;
            SEL_BDET: bus_rdata = bdet_q;
            SEL_OMB:  bus_rdata = ob_data;
            SEL_THR:  bus_rdata = thr_q;
            SEL_IMB:  bus_rdata = ib_data;
            default:  bus_rdata = '0;
          endcase
        end
      end
    end
  end

  assign ob_mbox_data = ob_data;
  assign ob_mbox_full = ob_full;
  assign bdet_val     = bdet_q;
  assign thr_val      = thr_q;
  assign fifo_clr     = clr_q;
  assign board_rst    = brst_q;

  AST_CLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> !fifo_clr); // R8
  AST_BRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> board_rst); // R11
  AST_NOP_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr == OFS_RST) |=> ($stable(mask_q) && $stable(thr_q) && $stable(bdet_q))); // R1
endmodule

// File: tb/fifo_host_regif_tb_top.sv
`timescale 1ns/1ps
module fifo_host_regif_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic ob_push, ib_pop;
  logic [7:0] ob_pdata;
  logic [7:0] ib_fdata = '0;
  logic ob_full_in = 0, ib_empty_in = 1, ob_afull_in = 0, ib_aempty_in = 0, bdet_hit_in = 0, perr_in = 0;
  logic [7:0] peer_stat = '0;
  logic bd_ob_take = 0, bd_ib_put = 0, bd_irq_en = 0;
  logic [7:0] bd_ib_data = '0;
  logic [7:0] ob_mbox_data, bdet_val, thr_val;
  logic ob_mbox_full, fifo_clr, board_rst, host_irq;

  int checks = 0;
  int errors = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  fifo_host_regif dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ob_push(ob_push), .ob_pdata(ob_pdata),
    .ib_pop(ib_pop), .ib_fdata(ib_fdata), .ob_full_in(ob_full_in), .ib_empty_in(ib_empty_in),
    .ob_afull_in(ob_afull_in), .ib_aempty_in(ib_aempty_in), .bdet_hit_in(bdet_hit_in),
    .perr_in(perr_in), .peer_stat(peer_stat), .bd_ob_take(bd_ob_take), .bd_ib_put(bd_ib_put),
    .bd_ib_data(bd_ib_data), .bd_irq_en(bd_irq_en), .ob_mbox_data(ob_mbox_data),
    .ob_mbox_full(ob_mbox_full), .bdet_val(bdet_val), .thr_val(thr_val), .fifo_clr(fifo_clr),
    .board_rst(board_rst), .host_irq(host_irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Entered at a falling edge; spans one rising edge; leaves at the next falling edge.
  task automatic acc(input logic is_rd, input logic [2:0] a, input logic [7:0] d, output logic [7:0] r);
    bus_addr = a; bus_wdata = d; bus_rd = is_rd; bus_wr = !is_rd;
    #1 r = bus_rdata;
    @(negedge clk);
    bus_rd = 0; bus_wr = 0;
  endtask

  task automatic pulse(ref logic s);
    s = 1; @(negedge clk); s = 0;
  endtask

  // {is_rd, addr, data/expected}
  localparam int NV = 29;
  localparam logic [11:0] VEC [NV] = '{
    {1'b1, 3'd2, 8'hA0},  // R5 flag set after reset (R4 layout: empty=bit5)
    {1'b1, 3'd2, 8'h20},  // R5 cleared by status read
    {1'b0, 3'd2, 8'h02},  // R2 select mask
    {1'b0, 3'd2, 8'h5A},
    {1'b0, 3'd2, 8'h02},
    {1'b1, 3'd2, 8'h5A},  // R2 mask readback
    {1'b1, 3'd2, 8'h20},  // R3 back to status
    {1'b0, 3'd2, 8'h05},
    {1'b0, 3'd2, 8'hC3},
    {1'b0, 3'd2, 8'h05},
    {1'b1, 3'd2, 8'hC3},  // R2 threshold
    {1'b0, 3'd2, 8'h03},
    {1'b0, 3'd2, 8'h0F},
    {1'b0, 3'd2, 8'h03},
    {1'b1, 3'd2, 8'h0F},  // R2 byte-detect
    {1'b0, 3'd2, 8'h07},
    {1'b1, 3'd2, 8'h20},  // R2 value 7 selects nothing
    {1'b0, 3'd2, 8'h09},
    {1'b1, 3'd2, 8'h20},  // R2 out-of-range value
    {1'b0, 3'd2, 8'h02},
    {1'b1, 3'd5, 8'h00},  // R1 unused offset reads zero
    {1'b0, 3'd4, 8'hFF},  // R1 ignored write
    {1'b1, 3'd2, 8'h5A},  // R3 pending index survived
    {1'b0, 3'd2, 8'h04},
    {1'b0, 3'd2, 8'h3C},
    {1'b0, 3'd2, 8'h04},
    {1'b1, 3'd2, 8'h3C},  // R9 outbound mailbox readback
    {1'b0, 3'd2, 8'h00},
    {1'b1, 3'd2, 8'h20}   // R2 value 0 selects nothing
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R7 irq after reset", {7'b0, host_irq}, 8'h00);
    chk("R11 board_rst idle", {7'b0, board_rst}, 8'h00);
    chk("R8 fifo_clr idle", {7'b0, fifo_clr}, 8'h00);
    chk("R9 mailbox empty at reset", {7'b0, ob_mbox_full}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][11], VEC[i][10:8], VEC[i][7:0], rv);
      if (VEC[i][11]) chk($sformatf("R2/R3 vector %0d", i), rv, VEC[i][7:0]);
    end

    // R9 board consumes outbound mailbox
    chk("R9 full after write", {7'b0, ob_mbox_full}, 8'h01);
    pulse(bd_ob_take);
    chk("R9 full cleared", {7'b0, ob_mbox_full}, 8'h00);
    acc(0, 2, 8'h04, rv); acc(1, 2, 0, rv);
    chk("R9 readback zero", rv, 8'h00);

    // R10 inbound mailbox
    bd_ib_data = 8'h77; pulse(bd_ib_put);
    acc(0, 2, 8'h06, rv); acc(0, 2, 8'h11, rv);
    acc(1, 2, 0, rv); chk("R10 status full bit", rv, 8'h24);
    acc(0, 2, 8'h06, rv); acc(1, 2, 0, rv); chk("R10 data ignored write", rv, 8'h77);
    acc(1, 2, 0, rv); chk("R10 full cleared by read", rv, 8'h20);

    // R6/R7 interrupt
    ob_full_in = 1; #1;
    chk("R7 irq disabled globally", {7'b0, host_irq}, 8'h00);
    @(negedge clk); pulse(bd_irq_en);
    chk("R6 irq on enabled bit", {7'b0, host_irq}, 8'h01);
    acc(0, 2, 8'h02, rv); acc(0, 2, 8'h00, rv);
    chk("R6 irq masked", {7'b0, host_irq}, 8'h00);

    // R8/R5 clear command
    acc(0, 2, 8'h04, rv); acc(0, 2, 8'h55, rv);
    chk("R9 full set again", {7'b0, ob_mbox_full}, 8'h01);
    acc(0, 2, 8'h01, rv); acc(0, 2, 8'h80, rv);
    chk("R8 fifo_clr pulse", {7'b0, fifo_clr}, 8'h01);
    chk("R8 mailbox emptied", {7'b0, ob_mbox_full}, 8'h00);
    chk("R5 unmaskable irq", {7'b0, host_irq}, 8'h01);
    @(negedge clk);
    chk("R8 fifo_clr one cycle", {7'b0, fifo_clr}, 8'h00);
    acc(1, 2, 0, rv); chk("R5 status with flag", rv, 8'hE0);
    chk("R5 irq gone after read", {7'b0, host_irq}, 8'h00);

    // R4/R8 shift mapping
    peer_stat = 8'h5C;
    acc(0, 2, 8'h01, rv); acc(0, 2, 8'h40, rv);
    acc(1, 2, 0, rv); chk("R4 shifted status", rv, 8'h5C);
    acc(0, 2, 8'h01, rv); acc(1, 2, 0, rv); chk("R8 command readback", rv, 8'h40);
    acc(0, 2, 8'h01, rv); acc(0, 2, 8'h00, rv);
    acc(1, 2, 0, rv); chk("R4 local status", rv, 8'h60);

    // R1 data port
    ib_fdata = 8'h3E;
    bus_addr = 0; bus_wdata = 8'hA5; bus_wr = 1; #1;
    chk("R1 push strobe", {7'b0, ob_push}, 8'h01);
    chk("R1 push data", ob_pdata, 8'hA5);
    @(negedge clk); bus_wr = 0;
    bus_rd = 1; #1;
    chk("R1 pop strobe", {7'b0, ib_pop}, 8'h01);
    chk("R1 pop data", bus_rdata, 8'h3E);
    @(negedge clk); bus_rd = 0;

    // R1 read at offset 7 has no effect
    acc(0, 2, 8'h02, rv); acc(0, 2, 8'h40, rv);
    acc(0, 2, 8'h02, rv); acc(1, 7, 0, rv);
    chk("R1 reset-offset read harmless", {7'b0, board_rst}, 8'h00);
    acc(1, 2, 0, rv); chk("R1 index kept past offset 7 read", rv, 8'h40);
    chk("R6 irq with mask 0x40", {7'b0, host_irq}, 8'h01);

    // R11 board reset
    acc(0, 2, 8'h05, rv);
    acc(0, 7, 8'h00, rv);
    chk("R11 board_rst pulse", {7'b0, board_rst}, 8'h01);
    chk("R11 irq disabled", {7'b0, host_irq}, 8'h00);
    acc(1, 2, 0, rv); chk("R11 index cleared, flag set", rv, 8'hE0);
    acc(0, 2, 8'h02, rv); acc(1, 2, 0, rv); chk("R11 mask reset", rv, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule